// File: doc/BRIEF.md
# Multilevel Cell Drift Test Controller

This controller runs a retention-drift test on an array of multilevel memory cells, each of which holds a thermometer-coded level. After a start request it fills a rectangle of the array with the all-ones code, which is the highest level. The rectangle's row and column bounds are given at start. It then stays idle for a programmable number of clock cycles so that stored charge can leak. Finally it reads the rectangle back in page mode, finishing every column of a row before it moves to the next row.

Every cell read produces one beat on a valid/ready result stream. The beat carries the row, the column, the raw code that was read, and a mismatch flag. A backend can use these beats to paint a drift bitmap in which a whole failing row or a whole failing column stands out. The controller also keeps running per-row and per-column mismatch tallies. A row is marked stuck on the beat of its last column when every cell in that row mismatched. A column is marked stuck on its beat in the last row when every cell in that column mismatched. The memory side is a plain synchronous port with one cycle of read latency.

Top module: `drift_test_ctrl`

## Requirements
- R1: After an accepted start, the controller issues one write per cycle (`mem_req_o=1`, `mem_we_o=1`) to every cell of the rectangle in row-major order. Each write carries the all-ones code, and every write comes before the first read.
- R2: The first read request follows the last write request by exactly `drift_cycles_i + 1` cycles. A count of 0 therefore puts the first read in the cycle right after the last write.
- R3: Reads cover every cell exactly once in row-major order (page mode). Each result beat carries that cell's row and column.
- R4: `res_code_o` is the code returned by the memory, unchanged. `res_mismatch_o` is 1 exactly when that code is not all ones.
- R5: While `res_valid_o=1` and `res_ready_i=0`, every result field holds steady and no memory request is issued. No beat is lost or repeated.
- R6: `res_row_stuck_o` is 1 only on the beat of the last column of a row, and only when every cell of that row mismatched. On all other beats it is 0.
- R7: `res_col_stuck_o` is 1 only on a beat in the last row, and only when every cell of that column mismatched. On all other beats it is 0.
- R8: `done_o` is high for exactly one cycle, in the cycle after the last beat is accepted. `busy_o` is 0 again in the cycle after that.
- R9: A start request while `busy_o=1` has no effect: the running test keeps its bounds, drift count and sequence.
- R10: While reset is active, and right after it, `busy_o`, `done_o`, `mem_req_o` and `res_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| row_first_i | input | ROW_W | First row of rectangle |
| row_last_i | input | ROW_W | Last row of rectangle (>= first) |
| col_first_i | input | COL_W | First column of rectangle |
| col_last_i | input | COL_W | Last column of rectangle (>= first) |
| drift_cycles_i | input | CNT_W | Idle cycles between write and read phase |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when 1, read when 0 |
| mem_row_o | output | ROW_W | Row address |
| mem_col_o | output | COL_W | Column address |
| mem_wdata_o | output | CODE_W | Write code |
| mem_rdata_i | input | CODE_W | Read code, valid one cycle after a read request |
| res_valid_o | output | 1 | Result beat valid |
| res_ready_i | input | 1 | Result beat accepted |
| res_row_o | output | ROW_W | Row of reported cell |
| res_col_o | output | COL_W | Column of reported cell |
| res_code_o | output | CODE_W | Raw code read from the cell |
| res_mismatch_o | output | 1 | Code differs from all ones |
| res_row_stuck_o | output | 1 | Whole row mismatched (last-column beat) |
| res_col_stuck_o | output | 1 | Whole column mismatched (last-row beat) |

## Verification
The bench builds the block with 3-bit row and column addresses and a 5-bit code. At that size the whole 8x8 array can be swept, so rectangles can touch both array edges, and a fault can cover a whole row or a whole column. It can also cover a single-cell rectangle, which is stuck in both directions at once. The drift counts used are small (0, 1, 3, 7 and 20), so the write-to-read spacing can be measured exactly. Alternating backpressure exercises the holding of beats, and an extra start pulse during the write phase checks that a busy controller ignores it.

// File: rtl/drift_pkg.sv
package drift_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_WAIT,
    ST_RD_REQ,
    ST_RD_CAP,
    ST_RD_OUT,
    ST_DONE
  } dt_state_e;
endpackage

// File: rtl/dt_addr_walker.sv
module dt_addr_walker #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             rewind_i,
  input  logic             step_i,
  input  logic [ROW_W-1:0] row_first_i,
  input  logic [ROW_W-1:0] row_last_i,
  input  logic [COL_W-1:0] col_first_i,
  input  logic [COL_W-1:0] col_last_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_first_o,
  output logic [ROW_W-1:0] row_last_o,
  output logic [COL_W-1:0] col_first_o,
  output logic [COL_W-1:0] col_last_o,
  output logic             last_o
);
  logic [ROW_W-1:0] row_q, rf_q, rl_q;
  logic [COL_W-1:0] col_q, cf_q, cl_q;
  logic             row_end;

  assign row_end = (col_q == cl_q);
  assign last_o  = row_end && (row_q == rl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
      rf_q  <= '0;
      rl_q  <= '0;
      cf_q  <= '0;
      cl_q  <= '0;
    end else if (load_i) begin
      rf_q  <= row_first_i;
      rl_q  <= row_last_i;
      cf_q  <= col_first_i;
      cl_q  <= col_last_i;
      row_q <= row_first_i;
      col_q <= col_first_i;
    end else if (rewind_i) begin
      row_q <= rf_q;
      col_q <= cf_q;
    end else if (step_i) begin
      if (row_end) begin
        col_q <= cf_q;
        row_q <= row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign row_o       = row_q;
  assign col_o       = col_q;
  assign row_first_o = rf_q;
  assign row_last_o  = rl_q;
  assign col_first_o = cf_q;
  assign col_last_o  = cl_q;

  // R3
  step_in_rect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && !rewind_i && !last_o |=> (row_q <= rl_q) && (col_q <= cl_q));
endmodule

// File: rtl/dt_drift_timer.sv
module dt_drift_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cycles_i,
  input  logic             tick_i,
  output logic             zero_o,
  output logic             one_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= cycles_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign one_o  = (cnt_q == CNT_W'(1));

  // R2
  tick_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> !zero_o);
endmodule

// File: rtl/dt_stuck_tracker.sv
module dt_stuck_tracker #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             upd_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             mismatch_i,
  input  logic [ROW_W-1:0] row_first_i,
  input  logic [ROW_W-1:0] row_last_i,
  input  logic [COL_W-1:0] col_first_i,
  input  logic [COL_W-1:0] col_last_i,
  output logic             row_stuck_o,
  output logic             col_stuck_o
);
  localparam int NCOL  = 1 << COL_W;
  localparam int TLY_W = ROW_W + 1;

  logic [TLY_W-1:0] col_tally_q [NCOL];
  logic [TLY_W-1:0] tally_next, n_rows;
  logic             row_all_q, row_all_next;

  assign n_rows       = {1'b0, row_last_i} - {1'b0, row_first_i} + TLY_W'(1);
  assign tally_next   = col_tally_q[col_i] + TLY_W'(mismatch_i);
  assign row_all_next = (col_i == col_first_i) ? mismatch_i : (row_all_q && mismatch_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCOL; i++) col_tally_q[i] <= '0;
      row_all_q <= 1'b0;
    end else if (clear_i) begin
      for (int i = 0; i < NCOL; i++) col_tally_q[i] <= '0;
      row_all_q <= 1'b0;
    end else if (upd_i) begin
      col_tally_q[col_i] <= tally_next;
      row_all_q          <= row_all_next;
    end
  end

  assign row_stuck_o = upd_i && (col_i == col_last_i) && row_all_next;
  assign col_stuck_o = upd_i && (row_i == row_last_i) && (tally_next == n_rows);

  // R6
  row_stuck_mis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_stuck_o |-> mismatch_i);
  // R7
  col_stuck_mis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_stuck_o |-> mismatch_i);
endmodule

// File: rtl/drift_test_ctrl.sv
module drift_test_ctrl
  import drift_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int CODE_W = 5,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  row_first_i,
  input  logic [ROW_W-1:0]  row_last_i,
  input  logic [COL_W-1:0]  col_first_i,
  input  logic [COL_W-1:0]  col_last_i,
  input  logic [CNT_W-1:0]  drift_cycles_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ROW_W-1:0]  mem_row_o,
  output logic [COL_W-1:0]  mem_col_o,
  output logic [CODE_W-1:0] mem_wdata_o,
  input  logic [CODE_W-1:0] mem_rdata_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [ROW_W-1:0]  res_row_o,
  output logic [COL_W-1:0]  res_col_o,
  output logic [CODE_W-1:0] res_code_o,
  output logic              res_mismatch_o,
  output logic              res_row_stuck_o,
  output logic              res_col_stuck_o
);
  localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};

  dt_state_e        state_q, state_d;
  logic             start_ok, accept, at_last, tmr_zero, tmr_one, mismatch;
  logic             wr_last, row_stuck, col_stuck;
  logic [ROW_W-1:0] cur_row, rf, rl;
  logic [COL_W-1:0] cur_col, cf, cl;

  assign start_ok = start_i && (state_q == ST_IDLE);
  assign accept   = (state_q == ST_RD_OUT) && res_ready_i;
  assign wr_last  = (state_q == ST_WRITE) && at_last;
  assign mismatch = (mem_rdata_i != TOP_CODE);

  dt_addr_walker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_ok),
    .rewind_i    (wr_last),
    .step_i      (((state_q == ST_WRITE) || accept) && !at_last),
    .row_first_i (row_first_i),
    .row_last_i  (row_last_i),
    .col_first_i (col_first_i),
    .col_last_i  (col_last_i),
    .row_o       (cur_row),
    .col_o       (cur_col),
    .row_first_o (rf),
    .row_last_o  (rl),
    .col_first_o (cf),
    .col_last_o  (cl),
    .last_o      (at_last)
  );

  dt_drift_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_ok),
    .cycles_i (drift_cycles_i),
    .tick_i   (state_q == ST_WAIT),
    .zero_o   (tmr_zero),
    .one_o    (tmr_one)
  );

  dt_stuck_tracker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_stuck (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start_ok),
    .upd_i       (state_q == ST_RD_CAP),
    .row_i       (cur_row),
    .col_i       (cur_col),
    .mismatch_i  (mismatch),
    .row_first_i (rf),
    .row_last_i  (rl),
    .col_first_i (cf),
    .col_last_i  (cl),
    .row_stuck_o (row_stuck),
    .col_stuck_o (col_stuck)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_WRITE;
      ST_WRITE:  if (at_last) state_d = tmr_zero ? ST_RD_REQ : ST_WAIT;
      ST_WAIT:   if (tmr_one) state_d = ST_RD_REQ;
      ST_RD_REQ: state_d = ST_RD_CAP;
      ST_RD_CAP: state_d = ST_RD_OUT;
      ST_RD_OUT: if (res_ready_i) state_d = at_last ? ST_DONE : ST_RD_REQ;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_row_o       <= '0;
      res_col_o       <= '0;
      res_code_o      <= '0;
      res_mismatch_o  <= 1'b0;
      res_row_stuck_o <= 1'b0;
      res_col_stuck_o <= 1'b0;
    end else if (state_q == ST_RD_CAP) begin
      res_row_o       <= cur_row;
      res_col_o       <= cur_col;
      res_code_o      <= mem_rdata_i;
      res_mismatch_o  <= mismatch;
      res_row_stuck_o <= row_stuck;
      res_col_stuck_o <= col_stuck;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign mem_req_o   = (state_q == ST_WRITE) || (state_q == ST_RD_REQ);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_row_o   = cur_row;
  assign mem_col_o   = cur_col;
  assign mem_wdata_o = TOP_CODE;
  assign res_valid_o = (state_q == ST_RD_OUT);

  // R5
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_row_o) && $stable(res_col_o)
      && $stable(res_code_o) && $stable(res_row_stuck_o) && $stable(res_col_stuck_o));
  // R5
  no_req_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !mem_req_o);
  // R3
  one_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |=> !mem_req_o);
  // R2
  wait_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> !mem_req_o && !res_valid_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  // R9
  busy_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(rf) && $stable(rl) && $stable(cf) && $stable(cl));
endmodule

// File: tb/sim_drift_test_ctrl.sv
`timescale 1ns/1ps
module sim_drift_test_ctrl;
  localparam int RW = 3;
  localparam int CW = 3;
  localparam int DW = 5;
  localparam int NR = 1 << RW;
  localparam int NC = 1 << CW;
  localparam logic [DW-1:0] ONES = '1;

  typedef struct packed {
    logic [2:0]  rf;
    logic [2:0]  rl;
    logic [2:0]  cf;
    logic [2:0]  cl;
    logic [15:0] drift;
    logic [2:0]  pat;
    logic        stall;
    logic        poke;
  } case_t;

  // pat: 0 none, 1 cell (rf,cl)=00111, 2 column cl=00000, 3 row rf=01111, 4 all=00011
  localparam case_t CASES [6] = '{
    '{3'd0, 3'd3, 3'd0, 3'd3, 16'd0,  3'd0, 1'b0, 1'b0},
    '{3'd1, 3'd4, 3'd2, 3'd6, 16'd7,  3'd1, 1'b1, 1'b1},
    '{3'd0, 3'd7, 3'd0, 3'd7, 16'd3,  3'd2, 1'b0, 1'b0},
    '{3'd2, 3'd5, 3'd1, 3'd3, 16'd1,  3'd3, 1'b1, 1'b0},
    '{3'd5, 3'd5, 3'd4, 3'd4, 16'd0,  3'd4, 1'b1, 1'b0},
    '{3'd3, 3'd4, 3'd0, 3'd7, 16'd20, 3'd4, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [RW-1:0] row_first = '0, row_last = '0;
  logic [CW-1:0] col_first = '0, col_last = '0;
  logic [31:0] drift = '0;
  logic busy, done, mem_req, mem_we;
  logic [RW-1:0] mem_row, res_row;
  logic [CW-1:0] mem_col, res_col;
  logic [DW-1:0] mem_wdata, res_code;
  logic [DW-1:0] mem_rdata = '0;
  logic res_valid, res_mis, res_rs, res_cs;
  logic res_ready = 1'b1;

  int checks = 0;
  int fails = 0;
  int c_rf, c_rl, c_cf, c_cl, c_pat;
  logic clr_store = 1'b0;
  logic [DW-1:0] store [NR][NC];

  always #2 clk = ~clk;

  drift_test_ctrl #(.ROW_W(RW), .COL_W(CW), .CODE_W(DW), .CNT_W(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .row_first_i(row_first), .row_last_i(row_last),
    .col_first_i(col_first), .col_last_i(col_last),
    .drift_cycles_i(drift), .busy_o(busy), .done_o(done),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_row_o(mem_row), .mem_col_o(mem_col),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .res_valid_o(res_valid), .res_ready_i(res_ready),
    .res_row_o(res_row), .res_col_o(res_col), .res_code_o(res_code),
    .res_mismatch_o(res_mis), .res_row_stuck_o(res_rs), .res_col_stuck_o(res_cs)
  );

  function automatic logic [DW:0] fault_of(int r, int c);
    case (c_pat)
      1: return (r == c_rf && c == c_cl) ? {1'b1, 5'b00111} : '0;
      2: return (c == c_cl) ? {1'b1, 5'b00000} : '0;
      3: return (r == c_rf) ? {1'b1, 5'b01111} : '0;
      4: return {1'b1, 5'b00011};
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] read_val(int r, int c);
    logic [DW:0] f;
    f = fault_of(r, c);
    return f[DW] ? f[DW-1:0] : store[r][c];
  endfunction

  function automatic bit row_all(int r);
    for (int c = c_cf; c <= c_cl; c++) if (!fault_of(r, c)[DW]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit col_all(int c);
    for (int r = c_rf; r <= c_rl; r++) if (!fault_of(r, c)[DW]) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (clr_store) begin
      for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) store[r][c] <= '0;
    end else if (mem_req && mem_we) begin
      store[mem_row][mem_col] <= mem_wdata;
    end
    if (mem_req && !mem_we) mem_rdata <= read_val(int'(mem_row), int'(mem_col));
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input case_t tc);
    int er, ec, wr, wc, nwr, nacc, total, cyc, last_wr, first_rd;
    bit held;
    logic [RW-1:0] h_row; logic [CW-1:0] h_col; logic [DW-1:0] h_code;
    logic h_rs, h_cs;
    c_rf = int'(tc.rf); c_rl = int'(tc.rl); c_cf = int'(tc.cf); c_cl = int'(tc.cl);
    c_pat = int'(tc.pat);
    total = (c_rl - c_rf + 1) * (c_cl - c_cf + 1);
    @(negedge clk); clr_store = 1'b1;
    @(negedge clk); clr_store = 1'b0;
    row_first = tc.rf; row_last = tc.rl; col_first = tc.cf; col_last = tc.cl;
    drift = 32'(tc.drift); start = 1'b1;
    @(negedge clk); start = 1'b0;
    er = c_rf; ec = c_cf; wr = c_rf; wc = c_cf;
    nwr = 0; nacc = 0; cyc = 0; last_wr = -1; first_rd = -1; held = 0;
    h_row = '0; h_col = '0; h_code = '0; h_rs = 0; h_cs = 0;
    while (nacc < total && cyc < 6000) begin
      cyc++;
      if (tc.poke && cyc == 2) begin
        start = 1'b1; row_first = '0; row_last = '1; col_first = '0; col_last = '1; drift = 32'd0;
      end else begin
        start = 1'b0; row_first = tc.rf; row_last = tc.rl; col_first = tc.cf; col_last = tc.cl;
        drift = 32'(tc.drift);
      end
      res_ready = tc.stall ? (cyc % 3 != 0) : 1'b1;
      if (mem_req && mem_we) begin
        // R1 / R9 write order and data
        check(first_rd < 0 && int'(mem_row) == wr && int'(mem_col) == wc && mem_wdata == ONES,
              "R1", "write addr/data", {mem_row, mem_col, mem_wdata}, {wr[RW-1:0], wc[CW-1:0], ONES});
        nwr++; last_wr = cyc;
        if (wc == c_cl) begin wc = c_cf; wr++; end else wc++;
      end
      if (mem_req && !mem_we && first_rd < 0) begin
        first_rd = cyc;
        check(nwr == total, "R1", "writes before read", nwr, total);
        // R2 drift spacing
        check(first_rd - last_wr == int'(tc.drift) + 1, "R2", "drift gap",
              first_rd - last_wr, int'(tc.drift) + 1);
      end
      if (res_valid) begin
        if (held) begin
          // R5 hold under stall
          check(res_row == h_row && res_col == h_col && res_code == h_code &&
                res_rs == h_rs && res_cs == h_cs, "R5", "stall hold",
                {res_row, res_col, res_code}, {h_row, h_col, h_code});
        end
        if (res_ready) begin
          logic [DW:0] f;
          logic [DW-1:0] ecode;
          f = fault_of(er, ec);
          ecode = f[DW] ? f[DW-1:0] : ONES;
          check(int'(res_row) == er && int'(res_col) == ec, "R3", "beat position",
                {res_row, res_col}, {er[RW-1:0], ec[CW-1:0]});
          check(res_code == ecode && res_mis == (ecode != ONES), "R4", "code/mismatch",
                {res_code, res_mis}, {ecode, ecode != ONES});
          check(res_rs == (ec == c_cl && row_all(er)), "R6", "row stuck",
                res_rs, (ec == c_cl && row_all(er)));
          check(res_cs == (er == c_rl && col_all(ec)), "R7", "col stuck",
                res_cs, (er == c_rl && col_all(ec)));
          nacc++;
          if (ec == c_cl) begin ec = c_cf; er++; end else ec++;
        end
      end
      held = res_valid && !res_ready;
      h_row = res_row; h_col = res_col; h_code = res_code; h_rs = res_rs; h_cs = res_cs;
      @(negedge clk);
    end
    start = 1'b0; res_ready = 1'b1;
    check(nacc == total, "R3", "beats accepted", nacc, total);
    check(done == 1'b1, "R8", "done after last accept", done, 1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R8", "done single pulse/idle", {done, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !mem_req && !res_valid, "R10", "in reset",
          {busy, done, mem_req, res_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mem_req && !res_valid, "R10", "after reset",
          {busy, done, mem_req, res_valid}, 0);

    foreach (CASES[i]) run_case(CASES[i]);

    // R10 reset mid-run
    @(negedge clk);
    row_first = 3'd0; row_last = 3'd7; col_first = 3'd0; col_last = 3'd7; drift = 32'd5;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    check(busy && mem_req && mem_we, "R1", "writing before reset", {busy, mem_req, mem_we}, 7);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !done && !mem_req && !res_valid, "R10", "mid-run reset",
          {busy, done, mem_req, res_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 run after reset uses fresh bounds
    run_case('{3'd7, 3'd7, 3'd6, 3'd7, 16'd2, 3'd2, 1'b1, 1'b0});

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule